// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small load-store microcontroller core. On each cycle where `op_valid` is high it takes two 8-bit operands (the second may be a register or an immediate; the block does not care which), a 5-bit operation code and a 3-bit flag index. It returns an 8-bit result with a write-enable, and it loads the updated flag byte into an internal status register at the next rising clock edge. The status register is the flag source for the carry-in of the chained operations. It is also visible at the `sreg` output.

Each operation touches only its own set of flags. Compares run the subtraction and update flags but do not raise the write-enable. Subtract-with-carry and compare-with-carry can only clear the zero flag, never set it, so a compare across several bytes ends with Z set only when every byte matched.

Top module: `alu8_status`

## Requirements
- R1: The status byte holds I, T, H, S, V, N, Z, C from bit 7 down to bit 0 and resets to 0x00. Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 OR, 6 EOR, 7 COM, 8 NEG, 9 INC, 10 DEC, 11 LSL, 12 ROL, 13 LSR, 14 ROR, 15 ASR, 16 SWAP, 17 CP, 18 CPC, 19 BSET, 20 BCLR. Only BSET and BCLR change I and T.
- R2: ADD gives a+b, and ADC gives a+b+C. Both update C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N, Z and S, and both write the result.
- R3: SUB gives a-b, and SBC gives a-b-C. C is the borrow out of bit 7 and H is the borrow into bit 4. V, N and S are updated. For SBC, Z is set only if the result is zero and Z was already set.
- R4: CP and CPC compute the same flags as SUB and SBC (including the Z chaining for CPC), with result_we low.
- R5: AND, OR and EOR update Z, N and S, force V to 0, and keep C and H.
- R6: COM gives 0xFF-a with C=1 and V=0, and keeps H. NEG gives 0x00-a and updates H, C (set when a is nonzero) and V (set for 0x80).
- R7: INC and DEC update Z, N, V and S, and keep C and H. V is set for INC of 0x7F and for DEC of 0x80.
- R8: LSL shifts left with 0 in, and ROL shifts left with C in. Both take C from bit 7 and H from bit 3. LSR shifts right with 0 in, ROR with C in, and ASR keeps bit 7. All three take C from bit 0 and keep H. Every shift sets V to N xor C.
- R9: SWAP exchanges the two nibbles of a and changes no flag.
- R10: BSET sets and BCLR clears status bit `fsel`. Neither changes any other bit nor writes a result.
- R11: While op_valid is low, and for codes 21 to 31, the status register holds and result_we is low.
- R12: After any flag-updating operation other than BSET or BCLR, S equals N xor V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| opa | input | 8 | First operand (destination value) |
| opb | input | 8 | Second operand (register or immediate) |
| fsel | input | 3 | Status bit index for BSET/BCLR |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result should be written back |
| sreg | output | 8 | Status register |

## Verification
The bench runs every operation code over all 256 values of the first operand, against a set of second operands that includes 0x00, 0x0F, 0x10, 0x7F, 0x80, 0xFF and the first operand itself. Because the carry and zero flags carry over from one vector to the next, both values of the incoming C and Z reach ADC, SBC, CPC, ROL and ROR. Expected values come from integer arithmetic. A design that takes H from the wrong bit would fail on the nibble boundaries 0x0F/0x10. A design that overwrites Z in SBC or CPC would set Z wrongly when a zero result follows a nonzero one. A design whose logic or INC/DEC operations disturb C, or whose compares write a result, would fail on those operations' checks. Sweeping the flag index covers every bit of BSET and BCLR.

// File: rtl/alu8_status.sv
module alu8_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [4:0] op,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic [2:0] fsel,
  output logic [7:0] result,
  output logic       result_we,
  output logic [7:0] sreg
);
  localparam logic [4:0] ADD = 5'd0,  ADC = 5'd1,  SUB = 5'd2,  SBC = 5'd3,
                         AND = 5'd4,  OR  = 5'd5,  EOR = 5'd6,  COM = 5'd7,
                         NEG = 5'd8,  INC = 5'd9,  DEC = 5'd10, LSL = 5'd11,
                         ROL = 5'd12, LSR = 5'd13, ROR = 5'd14, ASR = 5'd15,
                         SWP = 5'd16, CP  = 5'd17, CPC = 5'd18, BST = 5'd19,
                         BCL = 5'd20;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  logic [7:0] add_b, sub_a, sub_b, res, nx;
  logic       add_c, sub_c, we, upd, zchain;
  logic [8:0] sum, diff;

  assign add_b = (op == LSL || op == ROL) ? opa : opb;
  assign add_c = (op == ADC || op == ROL) & sreg[FC];
  assign sum   = {1'b0, opa} + {1'b0, add_b} + {8'd0, add_c};
  assign sub_a = (op == NEG) ? 8'h00 : opa;
  assign sub_b = (op == NEG) ? opa : opb;
  assign sub_c = (op == SBC || op == CPC) & sreg[FC];
  assign diff  = {1'b0, sub_a} - {1'b0, sub_b} - {8'd0, sub_c};

  always_comb begin
    res = opa; nx = sreg; we = 1'b0; upd = 1'b0; zchain = 1'b0;
    case (op)
      ADD, ADC, LSL, ROL: begin
        res = sum[7:0]; we = 1'b1; upd = 1'b1;
        nx[FC] = sum[8];
        nx[FH] = (opa[3] & add_b[3]) | (add_b[3] & ~res[3]) | (~res[3] & opa[3]);
        nx[FV] = (opa[7] & add_b[7] & ~res[7]) | (~opa[7] & ~add_b[7] & res[7]);
      end
      SUB, SBC, NEG, CP, CPC: begin
        res = diff[7:0]; we = !(op == CP || op == CPC); upd = 1'b1;
        zchain = (op == SBC || op == CPC);
        nx[FC] = diff[8];
        nx[FH] = (~sub_a[3] & sub_b[3]) | (sub_b[3] & res[3]) | (res[3] & ~sub_a[3]);
        nx[FV] = (sub_a[7] & ~sub_b[7] & ~res[7]) | (~sub_a[7] & sub_b[7] & res[7]);
      end
      AND: begin res = opa & opb; nx[FV] = 1'b0; we = 1'b1; upd = 1'b1; end
      OR:  begin res = opa | opb; nx[FV] = 1'b0; we = 1'b1; upd = 1'b1; end
      EOR: begin res = opa ^ opb; nx[FV] = 1'b0; we = 1'b1; upd = 1'b1; end
      COM: begin res = ~opa; nx[FC] = 1'b1; nx[FV] = 1'b0; we = 1'b1; upd = 1'b1; end
      INC: begin res = opa + 8'd1; nx[FV] = (opa == 8'h7F); we = 1'b1; upd = 1'b1; end
      DEC: begin res = opa - 8'd1; nx[FV] = (opa == 8'h80); we = 1'b1; upd = 1'b1; end
      LSR, ROR, ASR: begin
        res = {(op == ROR) ? sreg[FC] : (op == ASR) ? opa[7] : 1'b0, opa[7:1]};
        nx[FC] = opa[0]; nx[FV] = res[7] ^ opa[0]; we = 1'b1; upd = 1'b1;
      end
      SWP: begin res = {opa[3:0], opa[7:4]}; we = 1'b1; end
      BST: nx[fsel] = 1'b1;
      BCL: nx[fsel] = 1'b0;
      default: ;
    endcase
    if (upd) begin
      nx[FN] = res[7];
      nx[FZ] = zchain ? ((res == 8'h00) & sreg[FZ]) : (res == 8'h00);
      nx[FS] = res[7] ^ nx[FV];
    end
  end

  assign result    = res;
  assign result_we = op_valid & we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sreg <= 8'h00;
    else if (op_valid) sreg <= nx;
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] op,
  input logic [2:0] fsel,
  input logic       result_we,
  input logic [7:0] sreg
);
  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == 5'd17 || op == 5'd18) |-> !result_we);
  // R9
  swap_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 5'd16 |=> $stable(sreg));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(sreg));
  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !result_we);
  // R10
  bset_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 5'd19 |=> sreg[$past(fsel)]);
  // R10
  bclr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == 5'd20 |=> !sreg[$past(fsel)]);
  // R10
  flag_op_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == 5'd19 || op == 5'd20) |=>
      ((sreg ^ $past(sreg)) & ~(8'h01 << $past(fsel))) == 8'h00);
  // R12
  s_is_n_xor_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op <= 5'd18 && op != 5'd16 |=> sreg[4] == (sreg[3] ^ sreg[2]));
  // R1
  it_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op != 5'd19 && op != 5'd20 |=> $stable(sreg[7:6]));
endmodule

bind alu8_status alu8_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .fsel(fsel),
  .result_we(result_we), .sreg(sreg)
);

// File: tb/alu8_status_test.sv
module alu8_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] opa = 8'd0, opb = 8'd0;
  logic [2:0] fsel = 3'd0;
  logic [7:0] result, sreg;
  logic       result_we;
  int tests = 0, fails = 0;
  logic [7:0] es = 8'h00;
  bit done = 0;

  alu8_status uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
    .opa(opa), .opb(opb), .fsel(fsel), .result(result), .result_we(result_we),
    .sreg(sreg));

  always #2 clk = ~clk;

  function automatic string tag(input int o);
    if (o <= 1) return "R2";
    if (o <= 3) return "R3";
    if (o <= 6) return "R5";
    if (o <= 8) return "R6";
    if (o <= 10) return "R7";
    if (o <= 15) return "R8";
    if (o == 16) return "R9";
    if (o <= 18) return "R4";
    if (o <= 20) return "R10";
    return "R11";
  endfunction

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {we, result, status}
  function automatic logic [16:0] model(input int o, input int a, input int b,
                                        input int f, input logic [7:0] s);
    int r = a, c = 0, bb = 0, aa = 0, t = 0, ss = 0;
    logic we = 1'b0, upd = 1'b0, chain = 1'b0;
    logic [7:0] n = s;
    if (o <= 1 || o == 11 || o == 12) begin
      bb = (o >= 11) ? a : b;
      c = (o == 1 || o == 12) ? int'(s[0]) : 0;
      t = a + bb + c; r = t % 256;
      n[0] = t > 255; n[5] = (a % 16 + bb % 16 + c) > 15;
      ss = sgn(a) + sgn(bb) + c; n[3] = ss > 127 || ss < -128;
      we = 1; upd = 1;
    end else if (o == 2 || o == 3 || o == 8 || o == 17 || o == 18) begin
      aa = (o == 8) ? 0 : a; bb = (o == 8) ? a : b;
      c = (o == 3 || o == 18) ? int'(s[0]) : 0;
      t = aa - bb - c; r = (t + 512) % 256;
      n[0] = t < 0; n[5] = (aa % 16 - bb % 16 - c) < 0;
      ss = sgn(aa) - sgn(bb) - c; n[3] = ss > 127 || ss < -128;
      we = (o < 17); upd = 1; chain = (o == 3 || o == 18);
    end else if (o >= 4 && o <= 6) begin
      r = (o == 4) ? (a & b) : (o == 5) ? (a | b) : (a ^ b);
      n[3] = 0; we = 1; upd = 1;
    end else if (o == 7) begin
      r = 255 - a; n[0] = 1; n[3] = 0; we = 1; upd = 1;
    end else if (o == 9 || o == 10) begin
      r = (o == 9) ? (a + 1) % 256 : (a + 255) % 256;
      n[3] = (o == 9) ? (a == 127) : (a == 128); we = 1; upd = 1;
    end else if (o >= 13 && o <= 15) begin
      r = a / 2;
      if (o == 14 && s[0]) r = r + 128;
      if (o == 15) r = r + (a & 128);
      n[0] = a % 2; n[3] = (r >= 128) ^ (a % 2 == 1); we = 1; upd = 1;
    end else if (o == 16) begin
      r = (a % 16) * 16 + a / 16; we = 1;
    end else if (o == 19) n[f] = 1;
    else if (o == 20) n[f] = 0;
    if (upd) begin
      n[2] = r >= 128;
      n[1] = chain ? (r == 0 && s[1]) : (r == 0);
      n[4] = n[2] ^ n[3];
    end
    return {we, 8'(r), n};
  endfunction

  task automatic check(input string t, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (op %0d a %0h b %0h)", t, what, act, exp, op, opa, opb);
    end
  endtask

  task automatic run(input int o, input int a, input int b, input logic v);
    logic [16:0] m;
    @(negedge clk);
    op = 5'(o); opa = 8'(a); opb = 8'(b); fsel = 3'(a % 8); op_valid = v;
    #1;
    m = model(o, a, b, a % 8, es);
    if (v) begin
      check(tag(o), "we", result_we, m[16]);
      if (m[16]) check(tag(o), "result", result, m[15:8]);
    end else check("R11", "we idle", result_we, 0);
    @(posedge clk); #1;
    if (v) es = m[7:0];
    check(v ? tag(o) : "R11", "status", sreg, es);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int bl[10];
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset status", sreg, 0);
    rst_n = 1'b1;
    // flag ops over all indices, then idle cycles (R10, R11)
    for (int i = 0; i < 8; i++) run(19, i, 0, 1'b1);
    check("R1", "all set", sreg, 8'hFF);
    for (int i = 0; i < 8; i += 2) run(20, i, 0, 1'b1);
    for (int i = 0; i < 6; i++) run(i * 3, 8'h55, 8'hAA, 1'b0);
    for (int o = 0; o < 32; o++) begin
      for (int a = 0; a < 256; a++) begin
        bl = '{0, 1, 15, 16, 127, 128, 255, a, (a * 37 + 11) % 256, (a * 91 + o) % 256};
        for (int k = 0; k < 10; k++) run(o, a, bl[k], 1'b1);
      end
      if (o == 20) run(19, 7, 0, 1'b1);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule